// File: doc/BRIEF.md
# Oversampled Polyphase Channelizer

This block splits a stream of real input samples into eight complex sub-bands. It uses a polyphase analysis filterbank that is oversampled by 8/7. Because of the oversampling, a new set of channel outputs begins after every seven accepted input samples instead of every eight. Neighbouring bands therefore overlap, and every input frequency lands inside the passband of at least one channel. Removing the redundant overlap is left to later stages.

Samples pass through a 32-deep delay line. From it, eight polyphase branches of four fixed taps each form their partial sums. The block then circularly rotates the branch outputs by an amount that advances with every frame, which corrects the phase for the seven-sample hop. Last, a serial 8-point DFT produces one complex channel per clock. The real-to-complex conversion happens in the same step.

The core runs at twice the sample rate, so an input sample is offered at most every other cycle. The output stream carries the channel index, a start-of-frame pulse on channel 0, and a flag on the two outermost bands (DC and half-rate). Those two bands are unusable and must be discarded.

Top module: `osChannelizer`

## Requirements
- R1: A frame is produced after every 7th accepted sample. Counting starts at reset. Channel 0 of that frame is valid in the cycle that follows the second rising edge after the edge that accepted the 7th sample. No frame appears without 7 new samples.
- R2: The delay line holds d[j], the j-th newest accepted sample (j=0 is the newest), and is all zero after reset. The prototype tap is c[k] = 1024*(k+1) for k<16 and c[k] = 1024*(32-k) for k>=16. Branch n (0..7) gives v[n] = floor((sum over t=0..3 of c[n+8t]*d[n+8t]) / 65536).
- R3: For frame m (m=0 is the first frame after reset), the DFT input is y[n] = v[(n - s) mod 8] with s = (7*m) mod 8.
- R4: Channel k is computed with p = (n*k) mod 8 and twiddles C = {32767,23170,0,-23170,-32767,-23170,0,23170}[p] and S = {0,23170,32767,23170,0,-23170,-32767,-23170}[p]. The real accumulator is sum y[n]*C and the imaginary accumulator is -sum y[n]*S.
- R5: Each accumulator is rounded as floor((acc + 16384) / 32768) and then saturated to the signed 16-bit range [-32768, 32767].
- R6: The 8 channels of a frame appear on consecutive cycles in the order 0 to 7. outChan carries the index, and outSof is high only together with channel 0.
- R7: outEdge is high, with outValid, exactly for channels 0 and 4.
- R8: Reset clears the outputs, the delay line, the sample count within the frame and the frame index. A frame that was only partly collected is dropped.
- R9: inData is ignored while inValid is low. inValid is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the sample rate |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Marks a sample on inData |
| inData | input | 16 | Real input sample, two's complement |
| outValid | output | 1 | Channel output valid |
| outChan | output | 3 | Index of the channel on outRe/outIm |
| outRe | output | 16 | Real part of the channel sample |
| outIm | output | 16 | Imaginary part of the channel sample |
| outSof | output | 1 | Start of frame, on channel 0 |
| outEdge | output | 1 | Outermost band, to be discarded |

## Verification
On every cycle, the assertions check the output framing: the channel order, outSof appearing only with channel 0, the edge flag on channels 0 and 4, the input spacing, and that the number of frames never runs ahead of one per seven samples. The arithmetic cannot be checked this way. The tap weighting, the per-frame rotation, the twiddle products, rounding and saturation, and the output latency are shown only by the bench's scenarios, which compare every channel against a model built from the requirements. The loss of a partial frame across a reset is likewise shown only there. The scenarios cover DC, impulse, alternating, ramp and pseudo-random input, including a full-scale DC case that saturates.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int NCH   = 8;               // channels = DFT points
  localparam int TAPS  = 4;               // taps per polyphase branch
  localparam int HOP   = 7;               // input samples per frame
  localparam int SW    = 16;              // input sample width
  localparam int CW    = 16;              // coefficient width
  localparam int TW    = 16;              // twiddle width
  localparam int OW    = 16;              // output width per component
  localparam int BW    = 18;              // branch output width
  localparam int NTAP  = NCH * TAPS;
  localparam int CHW   = $clog2(NCH);
  localparam int CNTW  = $clog2(HOP);
  localparam int ACCW  = SW + CW + $clog2(TAPS);
  localparam int BSH   = ACCW - BW;       // branch scaling shift
  localparam int DW    = BW + TW + CHW + 1;
  localparam int TSH   = TW - 1;          // twiddle fraction bits

  typedef struct packed {
    logic           shift;    // accept sample into delay line
    logic           latch;    // capture rotated branch outputs
    logic [CHW-1:0] rot;      // rotation for the frame being latched
    logic           dftRun;   // DFT producing a channel this cycle
    logic [CHW-1:0] chan;     // channel being produced
  } ctrl_t;

  // Triangular prototype filter, computed rather than tabulated.
  function automatic logic signed [CW-1:0] coefAt(input int k);
    int v;
    v = (k < NTAP / 2) ? 1024 * (k + 1) : 1024 * (NTAP - k);
    return CW'(v);
  endfunction

  function automatic logic signed [TW-1:0] twCos(input logic [CHW-1:0] p);
    case (p)
      3'd0: return 16'sd32767;
      3'd1: return 16'sd23170;
      3'd2: return 16'sd0;
      3'd3: return -16'sd23170;
      3'd4: return -16'sd32767;
      3'd5: return -16'sd23170;
      3'd6: return 16'sd0;
      default: return 16'sd23170;
    endcase
  endfunction

  function automatic logic signed [TW-1:0] twSin(input logic [CHW-1:0] p);
    case (p)
      3'd0: return 16'sd0;
      3'd1: return 16'sd23170;
      3'd2: return 16'sd32767;
      3'd3: return 16'sd23170;
      3'd4: return 16'sd0;
      3'd5: return -16'sd23170;
      3'd6: return -16'sd32767;
      default: return -16'sd23170;
    endcase
  endfunction
endpackage

// File: rtl/osc_ctrl.sv
module osc_ctrl
  import osc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  output ctrl_t strb
);
  logic [CNTW-1:0] sampCnt;
  logic            latchQ;
  logic [CHW-1:0]  rotQ;
  logic            runQ;
  logic [CHW-1:0]  chanQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampCnt <= '0;
      latchQ  <= 1'b0;
      rotQ    <= '0;
      runQ    <= 1'b0;
      chanQ   <= '0;
    end else begin
      latchQ <= inValid && (sampCnt == CNTW'(HOP - 1));
      if (inValid)
        sampCnt <= (sampCnt == CNTW'(HOP - 1)) ? '0 : sampCnt + 1'b1;
      if (latchQ) begin
        rotQ  <= rotQ + CHW'(HOP);   // next frame's rotation, (7m) mod 8
        runQ  <= 1'b1;
        chanQ <= '0;
      end else if (runQ) begin
        chanQ <= chanQ + 1'b1;
        if (chanQ == CHW'(NCH - 1)) runQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.shift  = inValid;
    strb.latch  = latchQ;
    strb.rot    = rotQ;
    strb.dftRun = runQ;
    strb.chan   = chanQ;
  end
endmodule

// File: rtl/osc_datapath.sv
module osc_datapath
  import osc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_t                 strb,
  input  logic signed [SW-1:0]  inData,
  output logic                  outValid,
  output logic [CHW-1:0]        outChan,
  output logic signed [OW-1:0]  outRe,
  output logic signed [OW-1:0]  outIm,
  output logic                  outSof,
  output logic                  outEdge
);
  localparam logic signed [DW-1:0] RHALF = DW'(1) << (TSH - 1);
  localparam logic signed [DW-1:0] OMAX  = DW'((1 << (OW - 1)) - 1);
  localparam logic signed [DW-1:0] OMIN  = -OMAX - 1;

  logic signed [SW-1:0] dLine [NTAP];
  logic signed [BW-1:0] branchV [NCH];
  logic signed [BW-1:0] rotV [NCH];
  logic signed [BW-1:0] yReg [NCH];
  logic signed [DW-1:0] sumRe, sumIm;

  // Sample delay line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NTAP; i++) dLine[i] <= '0;
    end else if (strb.shift) begin
      dLine[0] <= inData;
      for (int i = 1; i < NTAP; i++) dLine[i] <= dLine[i-1];
    end
  end

  // Polyphase branches
  for (genvar n = 0; n < NCH; n++) begin : g_branch
    logic signed [ACCW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int t = 0; t < TAPS; t++)
        acc = acc + ACCW'(coefAt(n + NCH * t) * dLine[n + NCH * t]);
    end
    assign branchV[n] = acc[ACCW-1:BSH];
  end

  // Circular shift correcting the hop phase
  always_comb begin
    for (int n = 0; n < NCH; n++)
      rotV[n] = branchV[CHW'(n) - strb.rot];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int n = 0; n < NCH; n++) yReg[n] <= '0;
    end else if (strb.latch) begin
      for (int n = 0; n < NCH; n++) yReg[n] <= rotV[n];
    end
  end

  // Serial DFT: one channel per clock
  always_comb begin
    logic [CHW-1:0] p;
    p     = '0;
    sumRe = '0;
    sumIm = '0;
    for (int n = 0; n < NCH; n++) begin
      p     = CHW'(n) * strb.chan;
      sumRe = sumRe + DW'(yReg[n] * twCos(p));
      sumIm = sumIm - DW'(yReg[n] * twSin(p));
    end
  end

  function automatic logic signed [OW-1:0] rndSat(input logic signed [DW-1:0] a);
    logic signed [DW-1:0] r;
    r = (a + RHALF) >>> TSH;
    if (r > OMAX) r = OMAX;
    else if (r < OMIN) r = OMIN;
    return r[OW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outChan  <= '0;
      outRe    <= '0;
      outIm    <= '0;
      outSof   <= 1'b0;
      outEdge  <= 1'b0;
    end else begin
      outValid <= strb.dftRun;
      outSof   <= strb.dftRun && (strb.chan == '0);
      outEdge  <= strb.dftRun && ((strb.chan == '0) || (strb.chan == CHW'(NCH / 2)));
      if (strb.dftRun) begin
        outChan <= strb.chan;
        outRe   <= rndSat(sumRe);
        outIm   <= rndSat(sumIm);
      end
    end
  end
endmodule

// File: rtl/osChannelizer.sv
module osChannelizer
  import osc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [SW-1:0] inData,
  output logic                 outValid,
  output logic [CHW-1:0]       outChan,
  output logic signed [OW-1:0] outRe,
  output logic signed [OW-1:0] outIm,
  output logic                 outSof,
  output logic                 outEdge
);
  ctrl_t strb;

  osc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strb    (strb)
  );

  osc_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inData   (inData),
    .outValid (outValid),
    .outChan  (outChan),
    .outRe    (outRe),
    .outIm    (outIm),
    .outSof   (outSof),
    .outEdge  (outEdge)
  );
endmodule

// File: rtl/osc_chk.sv
module osc_chk
  import osc_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           outValid,
  input logic [CHW-1:0] outChan,
  input logic           outSof,
  input logic           outEdge
);
  int unsigned sampSeen, framesSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampSeen   <= 0;
      framesSeen <= 0;
    end else begin
      if (inValid) sampSeen <= sampSeen + 1;
      if (outSof)  framesSeen <= framesSeen + 1;
    end
  end

  AST_FRAME_BUDGET: assert property (@(posedge clk) disable iff (!rstN)
    ((framesSeen + 32'(outSof)) * HOP <= sampSeen)); // R1
  AST_SOF_ON_CH0: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> (outValid && outChan == '0)); // R6
  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outChan != CHW'(NCH - 1)) |=> (outValid && outChan == $past(outChan) + 1'b1)); // R6
  AST_CH0_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outChan == '0) |-> outSof); // R6
  AST_EDGE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    outEdge |-> (outValid && (outChan == '0 || outChan == CHW'(NCH / 2)))); // R7
  AST_EDGE_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outChan == '0 || outChan == CHW'(NCH / 2))) |-> outEdge); // R7
  AST_IN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> !inValid); // R9
endmodule

bind osChannelizer osc_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .outChan  (outChan),
  .outSof   (outSof),
  .outEdge  (outEdge)
);

// File: tb/osChannelizer_bench.sv
module osChannelizer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // kind, amplitude, sample count
  localparam int VEC [NV][3] = '{
    '{0, 1000, 21}, '{1, 20000, 35}, '{2, 3000, 28},
    '{3, 8000, 35}, '{4, 12000, 42}, '{0, 32767, 21}};

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0;
  logic signed [15:0] inData = '0;
  logic outValid, outSof, outEdge;
  logic [2:0] outChan;
  logic signed [15:0] outRe, outIm;

  int nChecks = 0, nErr = 0, satSeen = 0;
  bit finished = 0;

  longint bdl [32];
  int inFrame = 0, frameIdx = 0, expChan = 0;
  longint qRe [$], qIm [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  osChannelizer u_osChannelizer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outChan(outChan), .outRe(outRe), .outIm(outIm),
    .outSof(outSof), .outEdge(outEdge));

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint cB(input int k);
    return (k < 16) ? 1024 * (k + 1) : 1024 * (32 - k);
  endfunction
  function automatic longint cosB(input int p);
    int t [8] = '{32767, 23170, 0, -23170, -32767, -23170, 0, 23170};
    return t[p];
  endfunction
  function automatic longint sinB(input int p);
    int t [8] = '{0, 23170, 32767, 23170, 0, -23170, -32767, -23170};
    return t[p];
  endfunction
  function automatic longint sat16(input longint a);
    longint r;
    r = (a + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic modelReset();
    for (int j = 0; j < 32; j++) bdl[j] = 0;
    inFrame = 0; frameIdx = 0; expChan = 0;
    qRe.delete(); qIm.delete();
  endtask

  task automatic modelPush(input longint x);
    longint v [8], y [8];
    for (int j = 31; j > 0; j--) bdl[j] = bdl[j-1];
    bdl[0] = x;
    inFrame++;
    if (inFrame == 7) begin
      inFrame = 0;
      for (int n = 0; n < 8; n++) begin
        longint acc = 0;
        for (int t = 0; t < 4; t++) acc += cB(n + 8*t) * bdl[n + 8*t];
        v[n] = acc >>> 16;
      end
      for (int n = 0; n < 8; n++) y[n] = v[(n - (7*frameIdx) % 8 + 8) % 8];
      frameIdx++;
      for (int k = 0; k < 8; k++) begin
        longint re = 0, im = 0;
        for (int n = 0; n < 8; n++) begin
          re += y[n] * cosB((n*k) % 8);
          im -= y[n] * sinB((n*k) % 8);
        end
        qRe.push_back(sat16(re));
        qIm.push_back(sat16(im));
      end
    end
  endtask

  // One sample valid for one cycle, garbage on inData afterwards (R9)
  task automatic pushSample(input longint x, input int gap);
    @(negedge clk);
    inValid = 1'b1; inData = 16'(x);
    modelPush(x);
    @(negedge clk);
    inValid = 1'b0; inData = 16'sh7ABC;
    repeat (gap) @(negedge clk);
  endtask

  function automatic longint gen(input int kind, input int amp, input int i);
    case (kind)
      0: return amp;
      1: return (i == 0) ? amp : 0;
      2: return (i % 2) ? -amp : amp;
      3: return amp * ((i % 8) - 4) / 4;
      default: return ((longint'(i) * 1103515245 + 12345) >>> 8) % (2*amp + 1) - amp;
    endcase
  endfunction

  // Output monitor against model
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (qRe.size() == 0) begin
        chk("R1 output without pending frame", 1, 0);
      end else begin
        longint er, ei;
        er = qRe.pop_front(); ei = qIm.pop_front();
        chk("R2/R3/R4/R5 real", outRe, er);
        chk("R2/R3/R4/R5 imag", outIm, ei);
        chk("R6 channel order", outChan, expChan);
        chk("R6 sof", outSof, expChan == 0);
        chk("R7 edge flag", outEdge, (expChan == 0 || expChan == 4));
        if (er == 32767 || er == -32768) satSeen++;
        expChan = (expChan + 1) % 8;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    chk("R8 reset outValid", outValid, 0);
    chk("R8 reset outSof", outSof, 0);
    chk("R8 reset outEdge", outEdge, 0);
    rstN = 1'b1;

    // R1 latency: channel 0 after second edge following the 7th sample
    for (int i = 0; i < 6; i++) pushSample(500 * (i + 1), 1);
    pushSample(-4000, 0);
    chk("R1 not yet valid (latch cycle)", outValid, 0);
    @(negedge clk);
    chk("R1 not yet valid (DFT start)", outValid, 0);
    @(negedge clk);
    chk("R1 channel 0 valid", outValid, 1);
    chk("R1 channel 0 index", outChan, 0);
    repeat (12) @(negedge clk);

    // Vector table
    for (int v = 0; v < NV; v++)
      for (int i = 0; i < VEC[v][2]; i++)
        pushSample(gen(VEC[v][0], VEC[v][1], i), (v % 2) + ((i % 3) == 0));
    repeat (20) @(negedge clk);
    chk("R5 saturation reached", satSeen > 0, 1);
    chk("R1 all frames emitted", qRe.size(), 0);

    // R8: partial frame dropped by reset
    for (int i = 0; i < 3; i++) pushSample(9000, 1);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 outValid low in reset", outValid, 0);
    modelReset();
    rstN = 1'b1;
    for (int i = 0; i < 7; i++) pushSample(gen(1, 15000, i), 1);
    repeat (20) @(negedge clk);
    chk("R8 frame after reset emitted", qRe.size(), 0);

    // R9: garbage held with inValid low produces no frame
    inData = 16'sh5555;
    repeat (30) @(negedge clk);
    chk("R9 no output from idle data", outValid, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule